// File: doc/BRIEF.md
# Up/down wiper position counter

This block keeps the position of one tap selector on a 64-step resistor ladder. The position is a 6-bit value held in a register. Three kinds of load can set it. The first is a host write, which delivers a full byte from the serial front end. The second is a transfer from one of the stored data registers, where the value comes in already selected. The third is a recall of stored register 0. A step strobe with a direction bit can also move the position by a single step. The block turns the position into a one-hot select vector, so exactly one tap switch is closed at any time.

The surrounding control logic drives the strobes for one clock cycle each. The register file places the contents of stored register 0 on a dedicated input, and the block reloads from that input during reset and on every recall request. When several strobes arrive in the same cycle, a fixed priority picks one of them. The current position is also available as a zero-extended byte, ready to be shifted back to the host.

Top module: `wiper_pos_ctr`

## Requirements
- R1: While `rst_n` is low, the position loads the value on `dr0_val` at each rising clock edge.
- R2: `tap_sel` always has exactly one bit set. Its bit index equals the position, so position 0x00 drives bit 0 (low-end tap) and position 0x3F drives bit 63 (high-end tap).
- R3: A cycle with `host_wr` high loads `host_byte[5:0]` into the position. Bits 7:6 of `host_byte` have no effect on the result.
- R4: A cycle with `xfer_ld` high loads `xfer_val` into the position.
- R5: A cycle with `recall_req` high loads `dr0_val` into the position.
- R6: A cycle with `step_en` high and no load strobe adds one to the position when `step_up` is 1, and subtracts one when `step_up` is 0.
- R7: A step up at 0x3F leaves the position at 0x3F. A step down at 0x00 leaves it at 0x00. Neither direction wraps.
- R8: When strobes coincide, the fixed priority is recall, then host write, then transfer, then step.
- R9: `rd_byte` equals the position with bits 7:6 forced to zero.
- R10: A cycle with no strobe leaves the position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads `dr0_val` |
| dr0_val | input | 6 | Contents of stored register 0 |
| recall_req | input | 1 | Reload position from `dr0_val` |
| host_wr | input | 1 | Load from host byte |
| host_byte | input | 8 | Host data byte; the position is in bits 5:0 |
| xfer_ld | input | 1 | Load from selected data register |
| xfer_val | input | 6 | Selected data register contents |
| step_en | input | 1 | Move one step |
| step_up | input | 1 | Step direction: 1 is toward the high end, 0 toward the low end |
| pos | output | 6 | Current position |
| rd_byte | output | 8 | Position as a zero-extended byte |
| tap_sel | output | 64 | One-hot tap select |

## Verification
Directed sequences cover four situations. Each load source is driven alone. Host bytes are sent with their top bits set, which would expose a byte that is not masked. Long runs of steps up and down are driven into both ends, which tells saturation apart from wrap-around. All strobes are raised together, and then the higher sources are dropped one at a time, which checks each rung of the priority order. A pseudo-random stretch then mixes strobes and data on every cycle. Against a behavioural model, this catches ordering or decode errors that the directed cases miss.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   // Source chosen for the next position value, listed from highest priority down.
   typedef enum logic [2:0] {
      SRC_RECALL = 3'd0,
      SRC_HOST   = 3'd1,
      SRC_XFER   = 3'd2,
      SRC_STEP   = 3'd3,
      SRC_HOLD   = 3'd4
   } wpc_src_e;
endpackage

// File: rtl/wpc_step.sv
module wpc_step #(
   parameter int POS_W = 6
) (
   input  logic [POS_W-1:0] cur,
   input  logic             up,
   output logic [POS_W-1:0] nxt
);
   localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};
   localparam logic [POS_W-1:0] BOT = '0;
   localparam logic [POS_W-1:0] ONE = {{(POS_W-1){1'b0}}, 1'b1};

   logic at_top, at_bot;
   assign at_top = (cur == TOP);
   assign at_bot = (cur == BOT);

   // Saturating increment and decrement.
   always_comb begin
      if (up) nxt = at_top ? cur : cur + ONE;
      else    nxt = at_bot ? cur : cur - ONE;
   end
endmodule

// File: rtl/wpc_src_sel.sv
module wpc_src_sel
   import wpc_pkg::*;
#(
   parameter int POS_W = 6
) (
   input  logic             recall_req,
   input  logic             host_wr,
   input  logic             xfer_ld,
   input  logic             step_en,
   input  logic [POS_W-1:0] recall_val,
   input  logic [POS_W-1:0] host_val,
   input  logic [POS_W-1:0] xfer_val,
   input  logic [POS_W-1:0] step_val,
   input  logic [POS_W-1:0] cur,
   output wpc_src_e         src,
   output logic [POS_W-1:0] nxt
);
   // Fixed priority: recall, host write, transfer, then step.
   always_comb begin
      if (recall_req)   src = SRC_RECALL;
      else if (host_wr) src = SRC_HOST;
      else if (xfer_ld) src = SRC_XFER;
      else if (step_en) src = SRC_STEP;
      else              src = SRC_HOLD;
   end

   always_comb begin
      unique case (src)
         SRC_RECALL: nxt = recall_val;
         SRC_HOST:   nxt = host_val;
         SRC_XFER:   nxt = xfer_val;
         SRC_STEP:   nxt = step_val;
         default:    nxt = cur;
      endcase
   end
endmodule

// File: rtl/wpc_tap_dec.sv
module wpc_tap_dec #(
   parameter int POS_W     = 6,
   parameter bit USE_SHIFT = 1'b0
) (
   input  logic [POS_W-1:0]       pos,
   output logic [(1<<POS_W)-1:0]  sel
);
   localparam int TAPS = 1 << POS_W;

   generate
      if (USE_SHIFT) begin : g_shift
         localparam logic [TAPS-1:0] LSB = {{(TAPS-1){1'b0}}, 1'b1};
         assign sel = LSB << pos;
      end else begin : g_cmp
         for (genvar t = 0; t < TAPS; t++) begin : g_tap
            assign sel[t] = (pos == t[POS_W-1:0]);
         end
      end
   endgenerate
endmodule

// File: rtl/wiper_pos_ctr.sv
module wiper_pos_ctr
   import wpc_pkg::*;
#(
   parameter int POS_W     = 6,
   parameter int BYTE_W    = 8,
   parameter bit USE_SHIFT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [POS_W-1:0]        dr0_val,
   input  logic                    recall_req,
   input  logic                    host_wr,
   input  logic [BYTE_W-1:0]       host_byte,
   input  logic                    xfer_ld,
   input  logic [POS_W-1:0]        xfer_val,
   input  logic                    step_en,
   input  logic                    step_up,
   output logic [POS_W-1:0]        pos,
   output logic [BYTE_W-1:0]       rd_byte,
   output logic [(1<<POS_W)-1:0]   tap_sel
);
   localparam int               TAPS = 1 << POS_W;
   localparam int               PAD  = BYTE_W - POS_W;
   localparam logic [POS_W-1:0] TOP  = {POS_W{1'b1}};

   generate
      if (POS_W < 1 || POS_W > 10) begin : g_bad_pos
         $error("POS_W out of range");
      end
      if (BYTE_W <= POS_W) begin : g_bad_byte
         $error("BYTE_W must exceed POS_W");
      end
   endgenerate

   logic [POS_W-1:0] step_val, nxt_val;
   wpc_src_e         src;

   wpc_step #(.POS_W(POS_W)) u_step (
      .cur (pos),
      .up  (step_up),
      .nxt (step_val)
   );

   wpc_src_sel #(.POS_W(POS_W)) u_sel (
      .recall_req (recall_req),
      .host_wr    (host_wr),
      .xfer_ld    (xfer_ld),
      .step_en    (step_en),
      .recall_val (dr0_val),
      .host_val   (host_byte[POS_W-1:0]),
      .xfer_val   (xfer_val),
      .step_val   (step_val),
      .cur        (pos),
      .src        (src),
      .nxt        (nxt_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pos <= dr0_val;
      else        pos <= nxt_val;
   end

   wpc_tap_dec #(.POS_W(POS_W), .USE_SHIFT(USE_SHIFT)) u_dec (
      .pos (pos),
      .sel (tap_sel)
   );

   assign rd_byte = {{PAD{1'b0}}, pos};

   // R1
   reset_load_chk: assert property (@(posedge clk)
      !rst_n |=> pos == $past(dr0_val));
   // R2
   onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel) == 1 && tap_sel[pos]);
   // R3
   host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && !recall_req |=> pos == $past(host_byte[POS_W-1:0]));
   // R4
   xfer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ld && !host_wr && !recall_req |=> pos == $past(xfer_val));
   // R5
   recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |=> pos == $past(dr0_val));
   // R7
   sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && step_up && !recall_req && !host_wr && !xfer_ld && pos == TOP
      |=> pos == TOP);
   // R7
   sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && !step_up && !recall_req && !host_wr && !xfer_ld && pos == '0
      |=> pos == '0);
   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en && !recall_req && !host_wr && !xfer_ld |=> $stable(pos));
   // R9
   rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_byte[BYTE_W-1:POS_W] == '0 && rd_byte[POS_W-1:0] == pos);
endmodule

// File: tb/tb_wiper_pos_ctr.sv
`timescale 1ns/1ps
module tb_wiper_pos_ctr;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  dr0_val;
   logic        recall_req, host_wr, xfer_ld, step_en, step_up;
   logic [7:0]  host_byte;
   logic [5:0]  xfer_val;
   logic [5:0]  pos;
   logic [7:0]  rd_byte;
   logic [63:0] tap_sel;

   int checks = 0;
   int fails  = 0;
   int model  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   wiper_pos_ctr dut (
      .clk(clk), .rst_n(rst_n), .dr0_val(dr0_val), .recall_req(recall_req),
      .host_wr(host_wr), .host_byte(host_byte), .xfer_ld(xfer_ld),
      .xfer_val(xfer_val), .step_en(step_en), .step_up(step_up),
      .pos(pos), .rd_byte(rd_byte), .tap_sel(tap_sel)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // Behavioural next-value model from the requirements.
   function automatic int next_model(int cur);
      if (!rst_n)      return dr0_val;
      if (recall_req)  return dr0_val;
      if (host_wr)     return host_byte % 64;
      if (xfer_ld)     return xfer_val;
      if (step_en) begin
         if (step_up)  return (cur < 63) ? cur + 1 : cur;
         else          return (cur > 0)  ? cur - 1 : cur;
      end
      return cur;
   endfunction

   task automatic compare(string req);
      logic [63:0] exp_sel;
      exp_sel = 64'd1 << model;
      checks++;
      if (pos !== model[5:0]) begin
         fails++;
         $display("FAIL %s pos: actual %0h expected %0h", req, pos, model);
      end
      checks++;
      if (tap_sel !== exp_sel) begin
         fails++;
         $display("FAIL R2 %s tap_sel: actual %h expected %h", req, tap_sel, exp_sel);
      end
      checks++;
      if (rd_byte !== {2'b00, model[5:0]}) begin
         fails++;
         $display("FAIL R9 %s rd_byte: actual %0h expected %0h", req, rd_byte, model);
      end
   endtask

   // Drive at negedge, model advances with the edge, compare at next negedge.
   task automatic cyc(bit rc, bit hw, logic [7:0] hb, bit xl, logic [5:0] xv,
                      bit se, bit su, string req);
      recall_req = rc; host_wr = hw; host_byte = hb;
      xfer_ld = xl; xfer_val = xv; step_en = se; step_up = su;
      @(posedge clk);
      model = next_model(model);
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      int lfsr;
      rst_n = 1'b0; dr0_val = 6'h15;
      recall_req = 0; host_wr = 0; host_byte = 0; xfer_ld = 0;
      xfer_val = 0; step_en = 0; step_up = 0;
      @(negedge clk);
      cyc(0, 0, 8'h00, 0, 6'h00, 0, 0, "R1");
      cyc(0, 0, 8'h00, 0, 6'h00, 0, 0, "R1");
      rst_n = 1'b1;
      cyc(0, 0, 8'h00, 0, 6'h00, 0, 0, "R10");
      cyc(0, 0, 8'hFF, 0, 6'h2A, 0, 1, "R10");
      // R3: upper bits set must not matter
      cyc(0, 1, 8'hFF, 0, 6'h00, 0, 0, "R3");
      cyc(0, 1, 8'hC5, 0, 6'h00, 0, 0, "R3");
      cyc(0, 1, 8'h3F, 0, 6'h00, 0, 0, "R3");
      // R7: saturate at top
      for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, 0, 6'h00, 1, 1, "R7");
      // R6: step down
      for (int i = 0; i < 4; i++) cyc(0, 0, 8'h00, 0, 6'h00, 1, 0, "R6");
      // R4
      cyc(0, 0, 8'h00, 1, 6'h02, 0, 0, "R4");
      // R6/R7: walk down to zero and beyond
      for (int i = 0; i < 5; i++) cyc(0, 0, 8'h00, 0, 6'h00, 1, 0, "R7");
      for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, 0, 6'h00, 1, 1, "R6");
      // R5
      dr0_val = 6'h2C;
      cyc(1, 0, 8'h00, 0, 6'h00, 0, 0, "R5");
      // R8: priority ladder
      dr0_val = 6'h11;
      cyc(1, 1, 8'h07, 1, 6'h30, 1, 1, "R8");
      cyc(0, 1, 8'h87, 1, 6'h30, 1, 1, "R8");
      cyc(0, 0, 8'h07, 1, 6'h30, 1, 0, "R8");
      cyc(0, 0, 8'h07, 0, 6'h30, 1, 0, "R8");
      // Pseudo-random mix
      lfsr = 32'h1ACE5;
      for (int i = 0; i < 400; i++) begin
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
         dr0_val = lfsr[21:16];
         cyc(lfsr[0] & lfsr[1] & lfsr[2], lfsr[3] & lfsr[4], lfsr[15:8],
             lfsr[5] & lfsr[6], lfsr[27:22], lfsr[7], lfsr[28], "R8");
      end
      // R1 again mid-run
      rst_n = 1'b0; dr0_val = 6'h3E;
      cyc(0, 1, 8'h01, 0, 6'h00, 1, 1, "R1");
      rst_n = 1'b1;
      cyc(0, 0, 8'h00, 0, 6'h00, 1, 1, "R7");
      cyc(0, 0, 8'h00, 0, 6'h00, 1, 1, "R7");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule